// File: doc/BRIEF.md
# Monochrome Bitmap Raster Scanout

This block produces the raster timing and pixel stream for a 640 by 400 display at one bit per pixel. It runs from a 25 MHz pixel clock. Once every eight pixel clocks it reads one byte of the frame buffer from a memory that it shares with a small coprocessor CPU. For that single cycle it takes the bus by driving the CPU's ready and bus-enable inputs low. The byte it reads is then shifted out one pixel per clock as the video bit.

The read address comes from a dedicated linear counter. This counter returns to the frame buffer base while the frame is in vertical blanking, so the design needs no multiplier and no end-of-frame wrap logic. Blanking, sync and memory-enable are flags that flip when the counters reach fixed positions. The memory-enable flag runs one byte period (eight clocks) ahead of the visible window. This gives each byte a full byte period to arrive before its first pixel is shown.

Scan position (h, v) is (0, 0) in the first cycle after reset is released. From there h counts up to HT-1 and then v advances. Every output is registered and shows the state for position (h, v) during the following cycle.

Top module: `mono_vga_scanout`

## Requirements
- R1: During reset and in the first cycle after it: video_o = 0, hsync_o = 1, vsync_o = 0, cpu_rdy_o = 1, cpu_be_o = 1, mem_addr_o = FB_BASE. Scanning restarts at position (0, 0) when reset is released.
- R2: A line lasts HT = H_VIS+H_FP+H_SYNC+H_BP clocks. hsync_o is active-low and is 0 for positions h in [H_VIS+8+H_FP, H_VIS+8+H_FP+H_SYNC). It is 1 elsewhere.
- R3: A frame lasts VT = V_VIS+V_FP+V_SYNC+V_BP lines. vsync_o is active-high and is 1 on lines v in [V_VIS+V_FP, V_VIS+V_FP+V_SYNC). It is 0 elsewhere.
- R4: cpu_rdy_o and cpu_be_o are both 0 for exactly the positions where h mod 8 = 0, h < H_VIS and v < V_VIS. At every other position both are 1, so the CPU runs 7 of every 8 cycles in that region.
- R5: For a fetch at (h, v), mem_addr_o = FB_BASE + v*(H_VIS/8) + h/8. The sequence starts again at FB_BASE on every frame.
- R6: mem_rdata_i is captured in the fetch cycle. Pixel x of visible line v appears on video_o at position h = x+8. Its value is bit 7-(x mod 8) of the byte fetched for x/8, so the most significant bit is shown first.
- R7: video_o is 0 at every position with h < 8, h >= H_VIS+8 or v >= V_VIS.
- R8: No fetch happens on lines v >= V_VIS. mem_addr_o changes only at a fetch and holds its value between fetches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | ADDR_W | Shared memory read address |
| mem_rdata_i | input | 8 | Byte returned for mem_addr_o in the same cycle |
| cpu_rdy_o | output | 1 | CPU ready, low during a fetch |
| cpu_be_o | output | 1 | CPU bus enable, low during a fetch |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| video_o | output | 1 | Pixel bit |

## Verification
In the visible region, on every position with h mod 8 = 0, two events fall in the same cycle. The fetcher launches the next byte's read and stalls the CPU, and the serializer loads the byte that was fetched eight clocks earlier. If those two events are mis-ordered, one byte overwrites another. The bench provokes this on every group of every line with a memory whose content is a computed function of the address. Each cycle it compares video_o against that function applied to the expected byte address, and the address and stall outputs against positions derived from the scan count. A reset in the middle of a frame then shows that the address sequence and the pixel pipeline both start again from the origin.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int CNT_W        = 10;
    localparam int PIX_PER_BYTE = 8;
    localparam int PIX_SEL_W    = $clog2(PIX_PER_BYTE);

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [7:0]       pix_byte_t;

    typedef struct packed {
        logic hblank;
        logic vblank;
        logic men;
        logic hsync;
        logic vsync;
    } scan_flags_t;

    localparam scan_flags_t FLAGS_RST = '{hblank: 1'b1, vblank: 1'b1,
                                          men: 1'b0, hsync: 1'b0, vsync: 1'b0};

    function automatic logic flag_next(logic cur, logic set_hit, logic clr_hit);
        if (set_hit)      return 1'b1;
        else if (clr_hit) return 1'b0;
        else              return cur;
    endfunction

endpackage

// File: rtl/scan_timing.sv
module scan_timing
    import scan_pkg::*;
#(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 400,
    parameter int V_FP   = 12,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 35
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic grp0_o,
    output logic men_n_o,
    output logic hblank_n_o,
    output logic vblank_n_o,
    output logic hblank_q_o,
    output logic vblank_q_o,
    output logic hsync_o,
    output logic vsync_o
);

    localparam int HT       = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int VT       = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int DISP_BEG = PIX_PER_BYTE;
    localparam int DISP_END = H_VIS + PIX_PER_BYTE;
    localparam int HS_BEG   = DISP_END + H_FP;
    localparam int HS_END   = HS_BEG + H_SYNC;
    localparam int VS_BEG   = V_VIS + V_FP;
    localparam int VS_END   = VS_BEG + V_SYNC;

    localparam cnt_t HT_LAST   = cnt_t'(HT - 1);
    localparam cnt_t VT_LAST   = cnt_t'(VT - 1);
    localparam cnt_t C_DBEG    = cnt_t'(DISP_BEG);
    localparam cnt_t C_DEND    = cnt_t'(DISP_END);
    localparam cnt_t C_HVIS    = cnt_t'(H_VIS);
    localparam cnt_t C_HSBEG   = cnt_t'(HS_BEG);
    localparam cnt_t C_HSEND   = cnt_t'(HS_END);
    localparam cnt_t C_VVIS    = cnt_t'(V_VIS);
    localparam cnt_t C_VSBEG   = cnt_t'(VS_BEG);
    localparam cnt_t C_VSEND   = cnt_t'(VS_END);

    cnt_t        hcnt_q, vcnt_q;
    scan_flags_t flg_q, flg_n;
    logic        line_top;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
        end else if (hcnt_q == HT_LAST) begin
            hcnt_q <= '0;
            vcnt_q <= (vcnt_q == VT_LAST) ? '0 : vcnt_q + 1'b1;
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    always_comb begin
        line_top     = (hcnt_q == '0);
        flg_n.hblank = flag_next(flg_q.hblank, hcnt_q == C_DEND, hcnt_q == C_DBEG);
        flg_n.men    = flag_next(flg_q.men, line_top, hcnt_q == C_HVIS);
        flg_n.hsync  = flag_next(flg_q.hsync, hcnt_q == C_HSBEG, hcnt_q == C_HSEND);
        flg_n.vblank = flag_next(flg_q.vblank, line_top && (vcnt_q == C_VVIS),
                                 line_top && (vcnt_q == '0));
        flg_n.vsync  = flag_next(flg_q.vsync, line_top && (vcnt_q == C_VSBEG),
                                 line_top && (vcnt_q == C_VSEND));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) flg_q <= FLAGS_RST;
        else       flg_q <= flg_n;
    end

    assign grp0_o     = (hcnt_q[PIX_SEL_W-1:0] == '0);
    assign men_n_o    = flg_n.men;
    assign hblank_n_o = flg_n.hblank;
    assign vblank_n_o = flg_n.vblank;
    assign hblank_q_o = flg_q.hblank;
    assign vblank_q_o = flg_q.vblank;
    assign hsync_o    = ~flg_q.hsync;
    assign vsync_o    = flg_q.vsync;

    AST_HSYNC_IN_HBLANK: assert property (@(posedge clk_i) disable iff (rst_i)
        flg_q.hsync |-> flg_q.hblank); // R2
    AST_VSYNC_IN_VBLANK: assert property (@(posedge clk_i) disable iff (rst_i)
        flg_q.vsync |-> flg_q.vblank); // R3
    AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (hcnt_q == HT_LAST) |=> (hcnt_q == '0)); // R2

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int FB_BASE     = 'h8000,
    parameter int FRAME_BYTES = 32000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              grp0_i,
    input  logic              men_n_i,
    input  logic              vblank_n_i,
    output logic              fetch_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] BASE_A = FB_BASE[ADDR_W-1:0];

    logic              fetch_now;
    logic              fetch_q;
    logic [ADDR_W-1:0] lin_q;
    logic [ADDR_W-1:0] addr_q;

    assign fetch_now = men_n_i & ~vblank_n_i & grp0_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fetch_q <= 1'b0;
            lin_q   <= '0;
            addr_q  <= BASE_A;
        end else begin
            fetch_q <= fetch_now;
            if (vblank_n_i) begin
                lin_q <= '0;
            end else if (fetch_now) begin
                lin_q  <= lin_q + 1'b1;
                addr_q <= BASE_A + lin_q;
            end
        end
    end

    assign fetch_o = fetch_q;
    assign addr_o  = addr_q;

    AST_FETCH_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_q |=> !fetch_q); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !fetch_q |-> $stable(addr_q)); // R8
    AST_ADDR_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch_q |-> ((32'(addr_q) >= FB_BASE) &&
                     (32'(addr_q) < FB_BASE + FRAME_BYTES))); // R5

endmodule

// File: rtl/scan_shifter.sv
module scan_shifter
    import scan_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      fetch_i,
    input  pix_byte_t rdata_i,
    input  logic      grp0_i,
    input  logic      hblank_n_i,
    input  logic      vblank_n_i,
    output logic      video_o
);

    pix_byte_t hold_q;
    pix_byte_t shreg_q;
    logic      video_q;
    logic      disp;

    assign disp = ~hblank_n_i & ~vblank_n_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q  <= '0;
            shreg_q <= '0;
            video_q <= 1'b0;
        end else begin
            if (fetch_i) hold_q <= rdata_i;
            if (!disp) begin
                video_q <= 1'b0;
                shreg_q <= '0;
            end else if (grp0_i) begin
                video_q <= hold_q[7];
                shreg_q <= {hold_q[6:0], 1'b0};
            end else begin
                video_q <= shreg_q[7];
                shreg_q <= {shreg_q[6:0], 1'b0};
            end
        end
    end

    assign video_o = video_q;

    AST_LOAD_ON_GROUP: assert property (@(posedge clk_i) disable iff (rst_i)
        (disp && !grp0_i) |=> (video_q == $past(shreg_q[7]))); // R6

endmodule

// File: rtl/mono_vga_scanout.sv
module mono_vga_scanout
    import scan_pkg::*;
#(
    parameter int H_VIS   = 640,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int V_VIS   = 400,
    parameter int V_FP    = 12,
    parameter int V_SYNC  = 2,
    parameter int V_BP    = 35,
    parameter int ADDR_W  = 16,
    parameter int FB_BASE = 'h8000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              cpu_rdy_o,
    output logic              cpu_be_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              video_o
);

    localparam int BYTES_PER_ROW = H_VIS / PIX_PER_BYTE;
    localparam int FRAME_BYTES   = BYTES_PER_ROW * V_VIS;

    logic grp0, men_n, hblank_n, vblank_n, hblank_q, vblank_q;
    logic fetch;

    scan_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
    ) u_tim (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .grp0_o     (grp0),
        .men_n_o    (men_n),
        .hblank_n_o (hblank_n),
        .vblank_n_o (vblank_n),
        .hblank_q_o (hblank_q),
        .vblank_q_o (vblank_q),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o)
    );

    scan_fetch #(
        .ADDR_W(ADDR_W), .FB_BASE(FB_BASE), .FRAME_BYTES(FRAME_BYTES)
    ) u_fetch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .grp0_i     (grp0),
        .men_n_i    (men_n),
        .vblank_n_i (vblank_n),
        .fetch_o    (fetch),
        .addr_o     (mem_addr_o)
    );

    scan_shifter u_shift (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .fetch_i    (fetch),
        .rdata_i    (mem_rdata_i),
        .grp0_i     (grp0),
        .hblank_n_i (hblank_n),
        .vblank_n_i (vblank_n),
        .video_o    (video_o)
    );

    assign cpu_rdy_o = ~fetch;
    assign cpu_be_o  = ~fetch;

    AST_DARK_IN_BLANK: assert property (@(posedge clk_i) disable iff (rst_i)
        (hblank_q || vblank_q) |-> !video_o); // R7
    AST_NO_FETCH_VBLANK: assert property (@(posedge clk_i) disable iff (rst_i)
        fetch |-> !vblank_q); // R8
    AST_NO_FETCH_IN_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
        !hsync_o |-> (cpu_rdy_o && cpu_be_o)); // R4

endmodule

// File: tb/sim_mono_vga_scanout.sv
module sim_mono_vga_scanout;

    localparam int H_VIS = 32, H_FP = 8, H_SYNC = 8, H_BP = 16;
    localparam int V_VIS = 4,  V_FP = 1, V_SYNC = 1, V_BP = 2;
    localparam int ADDR_W = 16;
    localparam int FB_BASE = 'h8000;
    localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int FRAME = HT * VT;
    localparam int BPR = H_VIS / 8;
    localparam int HS_BEG = H_VIS + 8 + H_FP;
    localparam int VS_BEG = V_VIS + V_FP;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata;
    logic              cpu_rdy, cpu_be, hsync, vsync, video;
    int                tests = 0;
    int                fails = 0;
    bit                done = 1'b0;
    int                last_addr;

    always #5 clk = ~clk;

    function automatic logic [7:0] memfn(int a);
        logic [15:0] w;
        w = 16'(a);
        return w[7:0] ^ {w[2:0], w[7:3]} ^ 8'h5A ^ {w[11:8], w[15:12]};
    endfunction

    assign mem_rdata = memfn(int'(mem_addr));

    mono_vga_scanout #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .ADDR_W(ADDR_W), .FB_BASE(FB_BASE)
    ) u0 (
        .clk_i(clk), .rst_i(rst), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .cpu_rdy_o(cpu_rdy), .cpu_be_o(cpu_be), .hsync_o(hsync),
        .vsync_o(vsync), .video_o(video)
    );

    task automatic chk(string req, int act, int exp, int p);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, p, act, exp);
        end
    endtask

    task automatic chk_reset();
        chk("R1 video", int'(video), 0, -1);
        chk("R1 hsync", int'(hsync), 1, -1);
        chk("R1 vsync", int'(vsync), 0, -1);
        chk("R1 rdy", int'(cpu_rdy), 1, -1);
        chk("R1 be", int'(cpu_be), 1, -1);
        chk("R1 addr", int'(mem_addr), FB_BASE, -1);
    endtask

    task automatic run_scan(int nframes);
        last_addr = FB_BASE;
        for (int k = 1; k <= nframes * FRAME; k++) begin
            @(negedge clk);
            begin
                int p, h, v, x, exp_addr, exp_pix;
                bit fetch;
                p = k - 1;
                h = p % HT;
                v = (p / HT) % VT;
                fetch = (v < V_VIS) && (h < H_VIS) && (h % 8 == 0);
                chk("R2 hsync", int'(hsync),
                    (h >= HS_BEG && h < HS_BEG + H_SYNC) ? 0 : 1, p);
                chk("R3 vsync", int'(vsync),
                    (v >= VS_BEG && v < VS_BEG + V_SYNC) ? 1 : 0, p);
                if (v >= V_VIS)
                    chk("R8 no stall in vblank", int'(cpu_rdy), 1, p);
                else
                    chk("R4 rdy", int'(cpu_rdy), fetch ? 0 : 1, p);
                chk("R4 be", int'(cpu_be), fetch ? 0 : 1, p);
                if (fetch) begin
                    exp_addr = FB_BASE + v * BPR + h / 8;
                    chk("R5 addr", int'(mem_addr), exp_addr, p);
                    last_addr = exp_addr;
                end else begin
                    chk("R8 addr hold", int'(mem_addr), last_addr, p);
                end
                if (v < V_VIS && h >= 8 && h < H_VIS + 8) begin
                    x = h - 8;
                    exp_pix = int'(memfn(FB_BASE + v * BPR + x / 8)[7 - (x % 8)]);
                    chk("R6 pixel", int'(video), exp_pix, p);
                end else begin
                    chk("R7 dark", int'(video), 0, p);
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_reset();                              // R1 during reset
        rst = 1'b0;
        run_scan(3);
        rst = 1'b1;                               // R1 reset in mid-frame
        repeat (2) @(negedge clk);
        chk_reset();
        @(negedge clk);
        rst = 1'b0;
        run_scan(1);                              // restart from origin
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule